// File: doc/BRIEF.md
# Static Dataflow Template Firing Unit

This block keeps a small store of instruction templates for a static dataflow graph and runs them as their operands arrive. Each template holds an operator code, two destination fields and a left and right operand slot, each slot with its own presence flag. A token names a template, a port (left or right) and a value. It lands in the named slot and marks it present. A template becomes enabled when its operands are present and every slot it writes to is empty. An arc therefore never holds more than one token.

A two-state scheduler chooses among enabled templates. In state S_SEL it scans round-robin from the template after the last one that fired. If it finds one it latches it and takes transition SEL_TO_COMMIT; otherwise it stays in S_SEL (SEL_HOLD). In state S_COMMIT it checks the latched template again. If that template is still enabled, the unit computes the result, clears the template's operand flags and writes the result into each destination slot in the same edge. The state then always returns to S_SEL (COMMIT_TO_SEL). Results addressed outside the store appear on an output pulse. Templates are written through a load port, one per cycle.

A destination field is `{addr, port}`, with port 0 = left and 1 = right. The address of all ones is off-store: with port 1 it means external output, and with port 0 it means unused.

Top module: `dfu_fire_unit`

## Requirements
- R1: After reset no template is loaded, all presence flags are clear, and `out_valid` and `tok_err` are low. A token sent to an unloaded template is stored, but that template never fires.
- R2: A token whose address is below 2^AW-1 and whose target slot is empty is stored in that slot and sets its presence flag. `tok_port` 0 selects the left slot and 1 the right slot.
- R3: Binary operator codes fire only when both slots are present: 0 add, 1 left minus right, 2 multiply, 3 AND, 4 OR, 5 XOR. All results wrap to DW bits.
- R4: Unary operator codes need only the left slot: 6 multiplies the left operand by the parameter MULK, and 7 passes it through. The right-slot flag is ignored for them.
- R5: A template does not fire while any in-store destination slot it names holds a token. It fires once that slot has been consumed.
- R6: A firing clears the template's operand flags and writes the result into every in-store destination slot, using the port given in that destination field.
- R7: A firing that names the external destination (`{all ones, 1}`) in either field raises `out_valid` for exactly one cycle with the result on `out_data`, once per firing.
- R8: A token is dropped, and `tok_err` pulses in the next cycle, if it targets the all-ones address, an occupied slot, a slot that a firing writes in the same cycle, or a template being loaded in the same cycle.
- R9: The selection scan starts at the index after the last template that fired and wraps around. A firing takes an S_SEL cycle followed by an S_COMMIT cycle, so two firings are at least two cycles apart.
- R10: A load sets the template's operator and destination fields and clears both of its presence flags. A load has priority over a token or a firing that writes the same template in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Template load strobe |
| cfg_addr | input | AW | Template index to load |
| cfg_op | input | 3 | Operator code |
| cfg_dst1 | input | AW+1 | First destination `{addr, port}` |
| cfg_dst2 | input | AW+1 | Second destination `{addr, port}` |
| tok_valid | input | 1 | Incoming token strobe |
| tok_addr | input | AW | Target template of the token |
| tok_port | input | 1 | Target slot (0 left, 1 right) |
| tok_data | input | DW | Token value |
| out_valid | output | 1 | External result pulse |
| out_data | output | DW | External result value |
| tok_err | output | 1 | Token dropped in the previous cycle |

## Verification
The hardest case to reach is a template that has both operands present but cannot fire because its destination is occupied. Next to it is the case where two such blocked templates are released in the same cycle, which is the only way the round-robin order can be seen. The stimulus builds this on purpose. One template is fired into a sink that lacks its second operand. The blocked templates are then refilled, and a token sent to a slot of a blocked template is confirmed as refused. The sink is then drained step by step, and the order of the outputs shows which template the scan picked. Randomly chosen operators and operands from a fixed seed cover the arithmetic.

// File: rtl/dfu_pkg.sv
package dfu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_MULK = 3'd6,
        OP_PASS = 3'd7
    } dfu_op_e;

    typedef enum logic {
        S_SEL    = 1'b0,
        S_COMMIT = 1'b1
    } dfu_state_e;

    function automatic logic op_is_unary(input dfu_op_e op);
        return (op == OP_MULK) || (op == OP_PASS);
    endfunction

endpackage

// File: rtl/dfu_alu.sv
module dfu_alu
    import dfu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int MULK = 7
) (
    input  dfu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] KVAL = DW'(MULK);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_MULK: y = a * KVAL;
            OP_PASS: y = a;
        endcase
    end
endmodule

// File: rtl/dfu_rr_pick.sv
module dfu_rr_pick #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] gnt,
    output logic          any
);
    always_comb begin
        int j;
        any = 1'b0;
        gnt = '0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any = 1'b1;
                gnt = IW'(j);
            end
        end
    end
endmodule

// File: rtl/dfu_fire_unit.sv
module dfu_fire_unit
    import dfu_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DW   = 16,
    parameter int MULK = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [2:0]    cfg_op,
    input  logic [AW:0]   cfg_dst1,
    input  logic [AW:0]   cfg_dst2,
    input  logic          tok_valid,
    input  logic [AW-1:0] tok_addr,
    input  logic          tok_port,
    input  logic [DW-1:0] tok_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          tok_err
);
    localparam int N = (1 << AW) - 1;
    localparam logic [AW-1:0] A_OFF = {AW{1'b1}};
    localparam logic [AW:0]   D_EXT = {A_OFF, 1'b1};

    logic [N-1:0]  loaded, pres_l, pres_r, en;
    logic [DW-1:0] val_l [N];
    logic [DW-1:0] val_r [N];
    dfu_op_e       op_q  [N];
    logic [AW:0]   d1_q  [N];
    logic [AW:0]   d2_q  [N];

    dfu_state_e    state, nxt;
    logic [AW-1:0] sel_q, ptr_q, gnt;
    logic          any;
    logic [DW-1:0] res;

    function automatic logic dst_free(input logic [AW:0] d,
                                      input logic [N-1:0] pl,
                                      input logic [N-1:0] pr);
        if (d[AW:1] == A_OFF) return 1'b1;
        return d[0] ? !pr[d[AW:1]] : !pl[d[AW:1]];
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_enable
        assign en[g] = loaded[g] && pres_l[g]
                    && (op_is_unary(op_q[g]) || pres_r[g])
                    && dst_free(d1_q[g], pres_l, pres_r)
                    && dst_free(d2_q[g], pres_l, pres_r);
    end

    dfu_rr_pick #(.N(N), .IW(AW)) u_pick (
        .req(en), .ptr(ptr_q), .gnt(gnt), .any(any)
    );

    dfu_alu #(.DW(DW), .MULK(MULK)) u_alu (
        .op(op_q[sel_q]), .a(val_l[sel_q]), .b(val_r[sel_q]), .y(res)
    );

    // Commit-cycle decode
    logic        commit, wr1, wr2, to_ext, tok_ok, tok_occ, tok_clash;
    logic [AW:0] d1, d2;
    assign d1     = d1_q[sel_q];
    assign d2     = d2_q[sel_q];
    assign commit = (state == S_COMMIT) && en[sel_q];
    assign wr1    = commit && (d1[AW:1] != A_OFF);
    assign wr2    = commit && (d2[AW:1] != A_OFF);
    assign to_ext = commit && ((d1 == D_EXT) || (d2 == D_EXT));

    // Token acceptance
    assign tok_occ   = tok_port ? pres_r[tok_addr] : pres_l[tok_addr];
    assign tok_clash = (wr1 && d1 == {tok_addr, tok_port})
                    || (wr2 && d2 == {tok_addr, tok_port})
                    || (cfg_we && cfg_addr == tok_addr);
    assign tok_ok    = tok_valid && (tok_addr != A_OFF) && !tok_occ && !tok_clash;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_SEL;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            S_SEL:    nxt = any ? S_COMMIT : S_SEL;
            S_COMMIT: nxt = S_SEL;
        endcase
    end

    // Outputs and template store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded    <= '0;
            pres_l    <= '0;
            pres_r    <= '0;
            sel_q     <= '0;
            ptr_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            tok_err   <= 1'b0;
            for (int i = 0; i < N; i++) begin
                val_l[i] <= '0;
                val_r[i] <= '0;
                op_q[i]  <= OP_ADD;
                d1_q[i]  <= {A_OFF, 1'b0};
                d2_q[i]  <= {A_OFF, 1'b0};
            end
        end else begin
            out_valid <= to_ext;
            if (to_ext) out_data <= res;
            tok_err <= tok_valid && !tok_ok;

            if (state == S_SEL && any) sel_q <= gnt;

            if (commit) begin
                ptr_q <= (int'(sel_q) == N - 1) ? '0 : sel_q + 1'b1;
                pres_l[sel_q] <= 1'b0;
                pres_r[sel_q] <= 1'b0;
            end
            if (wr1) begin
                if (d1[0]) begin val_r[d1[AW:1]] <= res; pres_r[d1[AW:1]] <= 1'b1; end
                else       begin val_l[d1[AW:1]] <= res; pres_l[d1[AW:1]] <= 1'b1; end
            end
            if (wr2) begin
                if (d2[0]) begin val_r[d2[AW:1]] <= res; pres_r[d2[AW:1]] <= 1'b1; end
                else       begin val_l[d2[AW:1]] <= res; pres_l[d2[AW:1]] <= 1'b1; end
            end
            if (tok_ok) begin
                if (tok_port) begin val_r[tok_addr] <= tok_data; pres_r[tok_addr] <= 1'b1; end
                else          begin val_l[tok_addr] <= tok_data; pres_l[tok_addr] <= 1'b1; end
            end
            if (cfg_we && cfg_addr != A_OFF) begin
                loaded[cfg_addr] <= 1'b1;
                op_q[cfg_addr]   <= dfu_op_e'(cfg_op);
                d1_q[cfg_addr]   <= cfg_dst1;
                d2_q[cfg_addr]   <= cfg_dst2;
                pres_l[cfg_addr] <= 1'b0;
                pres_r[cfg_addr] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dfu_checker.sv
module dfu_checker
    import dfu_pkg::*;
#(
    parameter int AW = 3,
    parameter int N  = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tok_valid,
    input logic [AW-1:0] tok_addr,
    input logic          tok_err,
    input logic          out_valid,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_addr,
    input dfu_state_e    st,
    input logic [N-1:0]  pl,
    input logic [N-1:0]  pr
);
    localparam logic [AW-1:0] A_OFF = {AW{1'b1}};

    p_off_addr_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_addr == A_OFF |=> tok_err);

    p_out_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_out_after_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(st) == S_COMMIT);

    p_commit_returns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_COMMIT |=> st == S_SEL);

    p_load_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr != A_OFF |=> !pl[$past(cfg_addr)] && !pr[$past(cfg_addr)]);
endmodule

bind dfu_fire_unit dfu_checker #(.AW(AW), .N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_addr(tok_addr),
    .tok_err(tok_err), .out_valid(out_valid), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .st(state), .pl(pres_l), .pr(pres_r)
);

// File: tb/dfu_fire_unit_test.sv
module dfu_fire_unit_test;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int KM = 7;
    localparam logic [3:0] EXT  = 4'b1111;
    localparam logic [3:0] NONE = 4'b1110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, tok_valid = 1'b0, tok_port = 1'b0;
    logic [AW-1:0] cfg_addr = '0, tok_addr = '0;
    logic [2:0] cfg_op = '0;
    logic [AW:0] cfg_dst1 = '0, cfg_dst2 = '0;
    logic [DW-1:0] tok_data = '0;
    logic out_valid, tok_err;
    logic [DW-1:0] out_data;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    dfu_fire_unit #(.AW(AW), .DW(DW), .MULK(KM)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_op(cfg_op), .cfg_dst1(cfg_dst1), .cfg_dst2(cfg_dst2),
        .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_port(tok_port),
        .tok_data(tok_data), .out_valid(out_valid), .out_data(out_data),
        .tok_err(tok_err)
    );

    function automatic logic [3:0] dst(input int a, input bit p);
        return {a[2:0], p};
    endfunction

    function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a * b;
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: r = a * DW'(KM);
            default: r = a;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic load(input int a, input int op, input logic [3:0] d1, input logic [3:0] d2);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_op = op[2:0]; cfg_dst1 = d1; cfg_dst2 = d2;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int a, input bit p, input int v, output bit err);
        @(negedge clk);
        tok_valid = 1'b1; tok_addr = a[2:0]; tok_port = p; tok_data = v[DW-1:0];
        @(negedge clk);
        tok_valid = 1'b0;
        err = tok_err;
    endtask

    task automatic wait_out(output bit got, output logic [DW-1:0] d);
        got = 1'b0; d = '0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (out_valid) begin got = 1'b1; d = out_data; end
        end
    endtask

    task automatic quiet(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit e, g;
        logic [DW-1:0] d;
        void'($urandom(32'd2024));
        do_reset();

        // R1: reset state, unloaded template stays idle
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(tok_err == 1'b0, "R1", "tok_err after reset", int'(tok_err), 0);
        send(0, 0, 1, e);
        quiet(10, g);
        check(!g, "R1", "unloaded template fired", int'(g), 0);

        // R2/R3: add waits for both operands
        do_reset();
        load(0, 0, EXT, NONE);
        send(0, 0, 5, e);
        check(!e, "R2", "left token accepted", int'(e), 0);
        quiet(8, g);
        check(!g, "R3", "fired with only left", int'(g), 0);
        send(0, 1, 3, e);
        wait_out(g, d);
        check(g && d == 16'd8, "R3", "add result", int'(d), 8);

        // R4: unary scale by constant with left only
        load(1, 6, EXT, NONE);
        send(1, 0, 9, e);
        wait_out(g, d);
        check(g && d == 16'(9 * KM), "R4", "unary scale", int'(d), 9 * KM);

        // R6: one firing feeds both ports of a multiply
        load(2, 1, dst(3, 1), dst(3, 0));
        load(3, 2, EXT, NONE);
        send(2, 0, 9, e);
        send(2, 1, 4, e);
        wait_out(g, d);
        check(g && d == 16'd25, "R6", "fan-out to both ports", int'(d), 25);

        // R8: occupied slot drops token; off-store address rejected
        do_reset();
        load(0, 0, EXT, EXT);
        send(0, 0, 5, e);
        send(0, 0, 6, e);
        check(e, "R8", "occupied slot error", int'(e), 1);
        send(7, 0, 1, e);
        check(e, "R8", "off-store address error", int'(e), 1);
        send(0, 1, 1, e);
        wait_out(g, d);
        check(g && d == 16'd6, "R8", "dropped token kept original", int'(d), 6);
        @(negedge clk);
        check(!out_valid, "R7", "single pulse for two external dests", int'(out_valid), 0);

        // R5: one token per arc backpressure
        do_reset();
        load(4, 0, dst(5, 0), NONE);
        load(5, 0, EXT, NONE);
        send(4, 0, 1, e);
        send(4, 1, 2, e);
        quiet(5, g);
        send(4, 0, 10, e);
        send(4, 1, 20, e);
        quiet(6, g);
        check(!g, "R5", "no output while blocked", int'(g), 0);
        send(4, 0, 99, e);
        check(e, "R5", "blocked template kept operand", int'(e), 1);
        send(5, 1, 100, e);
        wait_out(g, d);
        check(g && d == 16'd103, "R5", "first result through sink", int'(d), 103);
        send(5, 1, 1, e);
        wait_out(g, d);
        check(g && d == 16'd31, "R5", "released template result", int'(d), 31);

        // R10: load clears presence
        do_reset();
        load(0, 0, EXT, NONE);
        send(0, 0, 7, e);
        load(0, 0, EXT, NONE);
        send(0, 1, 2, e);
        quiet(8, g);
        check(!g, "R10", "reload cleared left operand", int'(g), 0);
        send(0, 0, 3, e);
        wait_out(g, d);
        check(g && d == 16'd5, "R10", "result after reload", int'(d), 5);

        // R9: round-robin order past the last fired index
        do_reset();
        load(1, 7, dst(2, 0), NONE);
        load(4, 7, dst(2, 0), NONE);
        load(2, 0, EXT, NONE);
        send(1, 0, 11, e);
        quiet(5, g);
        send(1, 0, 22, e);
        send(4, 0, 44, e);
        quiet(5, g);
        send(2, 1, 0, e);
        wait_out(g, d);
        check(g && d == 16'd11, "R9", "first sink output", int'(d), 11);
        send(2, 1, 0, e);
        wait_out(g, d);
        check(g && d == 16'd44, "R9", "scan continues past sink", int'(d), 44);
        send(2, 1, 0, e);
        wait_out(g, d);
        check(g && d == 16'd22, "R9", "wrapped to lower index", int'(d), 22);

        // R3/R4: random operators and operands
        do_reset();
        for (int it = 0; it < 40; it++) begin
            int op;
            logic [DW-1:0] a, b;
            op = int'($urandom % 8);
            a = DW'($urandom);
            b = DW'($urandom);
            load(6, op, EXT, ($urandom % 2) ? EXT : NONE);
            send(6, 0, int'(a), e);
            if (op < 6) send(6, 1, int'(b), e);
            wait_out(g, d);
            check(g && d == model(op, a, b), (op < 6) ? "R3" : "R4",
                  "random operation", int'(d), int'(model(op, a, b)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule